// File: doc/BRIEF.md
# Priority Interrupt Selector with Preemption Stack

This block chooses which external interrupt a core services next. It takes flattened vectors of pending flags, enable flags and 4-bit priorities for `NUM_IRQ` interrupt lines. It finds the winning line and presents it as a read-only next-interrupt value, registered once. The value is laid out so that its index field can be used directly as a word offset into a handler table. Next to this value it keeps a context register. That register holds the interrupt being handled, a not-in-interrupt flag, a three-level stack of preemption priorities and a flag that arms the stack restore on return. From the context it also derives the machine external interrupt request.

The core drives single-cycle control pulses into the block: an update command (a write of 1 to the update bit of the next-interrupt value), a software write of the context register, entry to the external interrupt vector, entry to any other trap, and a return from trap. All pins are plain control and status signals; no data streams cross the boundary, so there is no valid/ready handshake. When several events occur in one cycle, only one acts, in this order: vector entry, then another trap, then return, then update, then software write. The timer-enable and soft-enable bits live outside the block. The block drives set and clear strobes for them and returns their prior values through the context read.

Top module: `irq_priority_selector`

## Requirements
- R1: Among lines that are pending and enabled, the line with the highest priority is selected, and equal priorities resolve to the lowest line number. The priority of line i is `irq_prio_i[4i+3:4i]`.
- R2: A line whose priority is below the context's previous-preempt field (context bits 27:24) is not eligible for selection, while a priority equal to it is eligible.
- R3: `next_rd_o`, registered one cycle after its inputs, carries the selected line number in bits 10:2 with all other bits zero. When no line qualifies it reads exactly 0x80000000 (bit 31 set, index zero). It resets to 0x80000000.
- R4: An update pulse loads the context current-IRQ field (bits 12:4) with the selected number and the no-IRQ flag (bit 15) with the selection's no-IRQ state. It loads preempt (bits 20:16) with the selected priority plus one, or with 16 when nothing is selected.
- R5: The context read value has pppreempt in bits 31:28, ppreempt in 27:24, preempt in 20:16, no-IRQ in 15, IRQ in 12:4, timer-enable save in 3, soft-enable save in 2, a clear-helper bit in 1 that always reads 0, and restore-armed in 0. It resets to 0x00008000. `ctx_rd_o` is a registered copy of the context as it stands after the current cycle's event.
- R6: On vector entry, pppreempt takes ppreempt, ppreempt takes preempt, preempt is kept, and restore-armed is set.
- R7: On a return with restore-armed set, preempt takes ppreempt, ppreempt takes pppreempt and pppreempt becomes 0. Any return clears restore-armed, and a return without it leaves the stack unchanged.
- R8: Taking a trap that is not an external interrupt clears restore-armed and leaves the stack unchanged.
- R9: A context write with bit 1 set pulses both enable-clear strobes, and its own read value shows the prior timer and soft enables in bits 3 and 2 (otherwise those bits read 0). Bits 3 and 2 of a write pulse the matching set strobes, unless bit 1 is also set, in which case the clear wins and no set strobe fires.
- R10: `eirq_req_o` is high exactly when some line is pending and enabled with priority greater than or equal to preempt.
- R11: A software context write loads pppreempt, ppreempt, preempt, no-IRQ, IRQ and restore-armed from the same bit positions of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pending_i | input | NUM_IRQ | Pending flag per line |
| irq_enable_i | input | NUM_IRQ | Enable flag per line |
| irq_prio_i | input | 4*NUM_IRQ | Packed 4-bit priority per line |
| next_upd_i | input | 1 | Update pulse: load context from the selection |
| ctx_wen_i | input | 1 | Software write of the context register |
| ctx_wdata_i | input | 32 | Context write data |
| vec_entry_i | input | 1 | Core enters the external interrupt vector |
| other_trap_i | input | 1 | Core takes any other trap |
| mret_i | input | 1 | Core returns from a trap |
| tmr_en_i | input | 1 | Current timer-interrupt enable |
| sw_en_i | input | 1 | Current soft-interrupt enable |
| next_rd_o | output | 32 | Registered next-interrupt value |
| ctx_rd_o | output | 32 | Registered context read value |
| eirq_req_o | output | 1 | Machine external interrupt request |
| tmr_en_clr_o | output | 1 | Clear strobe for the timer enable |
| sw_en_clr_o | output | 1 | Clear strobe for the soft enable |
| tmr_en_set_o | output | 1 | Set strobe for the timer enable |
| sw_en_set_o | output | 1 | Set strobe for the soft enable |

## Verification
Some properties are checked on every cycle. The assertions check that a selected line is really pending and enabled, and that it meets the ppreempt floor. They check that the next-interrupt value never carries stray bits, that a clear strobe never coincides with a set strobe, and that each stack transition moves the fields exactly as the push, pop, trap and empty-update rules demand. Other behaviour only the bench scenarios can show. This covers which line wins among competing priorities and indices, the boundary where a priority equals the floor, the preempt value loaded by an update, and a return without the restore flag. It also covers software field writes and the save bits read back during a clear.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int PRIO_W = 4;
  localparam int PRE_W  = PRIO_W + 1;
  localparam int IDX_W  = 9;
  localparam int MAX_IRQ = 1 << IDX_W;

  typedef struct packed {
    logic [PRIO_W-1:0] ppp;
    logic [PRIO_W-1:0] pp;
    logic [PRE_W-1:0]  pre;
    logic              noirq;
    logic [IDX_W-1:0]  irq;
    logic              arm;
  } ctx_t;

  localparam ctx_t CTX_RESET = '{ppp: '0, pp: '0, pre: '0, noirq: 1'b1, irq: '0, arm: 1'b0};

  function automatic logic [31:0] pack_ctx(ctx_t c, logic tsave, logic ssave);
    return {c.ppp, c.pp, 3'b000, c.pre, c.noirq, 2'b00, c.irq, tsave, ssave, 1'b0, c.arm};
  endfunction

  function automatic logic [31:0] pack_next(logic valid, logic [IDX_W-1:0] idx);
    return {~valid, 20'd0, idx, 2'b00};
  endfunction
endpackage

// File: rtl/irqsel_arbiter.sv
module irqsel_arbiter
  import irqsel_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0]        pend,
  input  logic [NUM_IRQ-1:0]        en,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         sel_floor,
  input  logic [PRE_W-1:0]          gate_floor,
  output logic                      sel_valid,
  output logic [IDX_W-1:0]          sel_idx,
  output logic [PRIO_W-1:0]         sel_prio,
  output logic                      gate_any
);
  logic [PRIO_W-1:0] prio_arr [NUM_IRQ];
  logic [NUM_IRQ-1:0] cand;
  logic [NUM_IRQ-1:0] gate;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign prio_arr[g] = prio[g*PRIO_W +: PRIO_W];
    assign cand[g] = pend[g] & en[g] & (prio_arr[g] >= sel_floor);
    assign gate[g] = pend[g] & en[g] & ({1'b0, prio_arr[g]} >= gate_floor);
  end

  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    sel_prio  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!sel_valid || prio_arr[i] > sel_prio)) begin
        sel_valid = 1'b1;
        sel_idx   = IDX_W'(i);
        sel_prio  = prio_arr[i];
      end
    end
  end

  assign gate_any = |gate;
endmodule

// File: rtl/irqsel_enable_helper.sv
module irqsel_enable_helper (
  input  logic wen,
  input  logic clr_bit,
  input  logic tmr_set_bit,
  input  logic sw_set_bit,
  input  logic tmr_en,
  input  logic sw_en,
  output logic tmr_clr,
  output logic sw_clr,
  output logic tmr_set,
  output logic sw_set,
  output logic tmr_save,
  output logic sw_save
);
  logic clr_req;
  assign clr_req  = wen & clr_bit;
  assign tmr_clr  = clr_req;
  assign sw_clr   = clr_req;
  assign tmr_set  = wen & tmr_set_bit & ~clr_req;
  assign sw_set   = wen & sw_set_bit & ~clr_req;
  assign tmr_save = clr_req & tmr_en;
  assign sw_save  = clr_req & sw_en;
endmodule

// File: rtl/irqsel_context.sv
module irqsel_context
  import irqsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_entry,
  input  logic              other_trap,
  input  logic              mret,
  input  logic              upd,
  input  logic              wen,
  input  logic [31:0]       wdata,
  input  logic              sel_valid,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [PRIO_W-1:0] sel_prio,
  output ctx_t              ctx_q,
  output ctx_t              ctx_d
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[23:21], wdata[14:13], wdata[3:1]};

  always_comb begin
    ctx_d = ctx_q;
    if (vec_entry) begin
      ctx_d.ppp = ctx_q.pp;
      ctx_d.pp  = ctx_q.pre[PRIO_W-1:0];
      ctx_d.arm = 1'b1;
    end else if (other_trap) begin
      ctx_d.arm = 1'b0;
    end else if (mret) begin
      if (ctx_q.arm) begin
        ctx_d.pre = {1'b0, ctx_q.pp};
        ctx_d.pp  = ctx_q.ppp;
        ctx_d.ppp = '0;
      end
      ctx_d.arm = 1'b0;
    end else if (upd) begin
      ctx_d.irq   = sel_idx;
      ctx_d.noirq = ~sel_valid;
      ctx_d.pre   = sel_valid ? ({1'b0, sel_prio} + PRE_W'(1)) : PRE_W'(1 << PRIO_W);
    end else if (wen) begin
      ctx_d.ppp   = wdata[31:28];
      ctx_d.pp    = wdata[27:24];
      ctx_d.pre   = wdata[20:16];
      ctx_d.noirq = wdata[15];
      ctx_d.irq   = wdata[12:4];
      ctx_d.arm   = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctx_q <= CTX_RESET;
    else        ctx_q <= ctx_d;
  end

  // R6: vector entry pushes the priority stack and arms the restore
  a_r6_push: assert property (@(posedge clk) disable iff (!rst_n)
    vec_entry |=> (ctx_q.ppp == $past(ctx_q.pp)) && (ctx_q.pp == $past(ctx_q.pre[PRIO_W-1:0]))
                  && (ctx_q.pre == $past(ctx_q.pre)) && ctx_q.arm);

  // R7: armed return pops the stack and disarms
  a_r7_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && !vec_entry && !other_trap && ctx_q.arm) |=>
      (ctx_q.ppp == '0) && (ctx_q.pre == {1'b0, $past(ctx_q.pp)}) && !ctx_q.arm);

  // R7: unarmed return keeps the stack
  a_r7_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && !vec_entry && !other_trap && !ctx_q.arm) |=> $stable(ctx_q));

  // R8: other trap disarms the restore
  a_r8_other_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (other_trap && !vec_entry) |=> !ctx_q.arm && (ctx_q.pre == $past(ctx_q.pre)));

  // R4: an update with nothing selected disables preemption
  a_r4_empty_update: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !vec_entry && !other_trap && !mret && !sel_valid) |=>
      (ctx_q.pre == PRE_W'(1 << PRIO_W)) && ctx_q.noirq && (ctx_q.irq == '0));
endmodule

// File: rtl/irq_priority_selector.sv
module irq_priority_selector
  import irqsel_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        irq_pending_i,
  input  logic [NUM_IRQ-1:0]        irq_enable_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio_i,
  input  logic                      next_upd_i,
  input  logic                      ctx_wen_i,
  input  logic [31:0]               ctx_wdata_i,
  input  logic                      vec_entry_i,
  input  logic                      other_trap_i,
  input  logic                      mret_i,
  input  logic                      tmr_en_i,
  input  logic                      sw_en_i,
  output logic [31:0]               next_rd_o,
  output logic [31:0]               ctx_rd_o,
  output logic                      eirq_req_o,
  output logic                      tmr_en_clr_o,
  output logic                      sw_en_clr_o,
  output logic                      tmr_en_set_o,
  output logic                      sw_en_set_o
);
  localparam logic [31:0] NEXT_RESET = 32'h8000_0000;

  logic              sel_valid;
  logic [IDX_W-1:0]  sel_idx;
  logic [PRIO_W-1:0] sel_prio;
  logic              tmr_save, sw_save;
  ctx_t              ctx_q, ctx_d;

  if (NUM_IRQ < 1 || NUM_IRQ > MAX_IRQ) begin : g_bad_count
    initial $error("NUM_IRQ out of range");
  end

  irqsel_arbiter #(.NUM_IRQ(NUM_IRQ)) arb_i (
    .pend       (irq_pending_i),
    .en         (irq_enable_i),
    .prio       (irq_prio_i),
    .sel_floor  (ctx_q.pp),
    .gate_floor (ctx_q.pre),
    .sel_valid  (sel_valid),
    .sel_idx    (sel_idx),
    .sel_prio   (sel_prio),
    .gate_any   (eirq_req_o)
  );

  irqsel_context ctx_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec_entry  (vec_entry_i),
    .other_trap (other_trap_i),
    .mret       (mret_i),
    .upd        (next_upd_i),
    .wen        (ctx_wen_i),
    .wdata      (ctx_wdata_i),
    .sel_valid  (sel_valid),
    .sel_idx    (sel_idx),
    .sel_prio   (sel_prio),
    .ctx_q      (ctx_q),
    .ctx_d      (ctx_d)
  );

  irqsel_enable_helper ts_i (
    .wen         (ctx_wen_i),
    .clr_bit     (ctx_wdata_i[1]),
    .tmr_set_bit (ctx_wdata_i[3]),
    .sw_set_bit  (ctx_wdata_i[2]),
    .tmr_en      (tmr_en_i),
    .sw_en       (sw_en_i),
    .tmr_clr     (tmr_en_clr_o),
    .sw_clr      (sw_en_clr_o),
    .tmr_set     (tmr_en_set_o),
    .sw_set      (sw_en_set_o),
    .tmr_save    (tmr_save),
    .sw_save     (sw_save)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_rd_o <= NEXT_RESET;
      ctx_rd_o  <= pack_ctx(CTX_RESET, 1'b0, 1'b0);
    end else begin
      next_rd_o <= pack_next(sel_valid, sel_idx);
      ctx_rd_o  <= pack_ctx(ctx_d, tmr_save, sw_save);
    end
  end

  // R3: no stray bits in the next-interrupt value
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (next_rd_o[30:11] == '0) && (next_rd_o[1:0] == 2'b00));

  // R3: index field is zero when nothing qualifies
  a_r3_noirq_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    next_rd_o[31] |-> (next_rd_o[10:2] == '0));

  // R1: a selected line is pending and enabled
  a_r1_sel_live: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (((irq_pending_i & irq_enable_i) >> sel_idx) & NUM_IRQ'(1)) != '0);

  // R2: a selected line meets the previous-preempt floor
  a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_prio >= ctx_q.pp));

  // R9: clear and set strobes never fire together
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmr_en_clr_o && tmr_en_set_o) && !(sw_en_clr_o && sw_en_set_o));
endmodule

// File: tb/irq_priority_selector_tb_top.sv
`timescale 1ns/1ps
module irq_priority_selector_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pend = '0, en = '0;
  logic [N*4-1:0] prio = '0;
  logic upd = 0, wen = 0, vent = 0, otrap = 0, mret = 0, tmr_en = 0, sw_en = 0;
  logic [31:0] wdata = '0;
  logic [31:0] next_rd, ctx_rd;
  logic eirq, tclr, sclr, tset, sset;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  irq_priority_selector #(.NUM_IRQ(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pending_i(pend), .irq_enable_i(en), .irq_prio_i(prio),
    .next_upd_i(upd), .ctx_wen_i(wen), .ctx_wdata_i(wdata), .vec_entry_i(vent),
    .other_trap_i(otrap), .mret_i(mret), .tmr_en_i(tmr_en), .sw_en_i(sw_en),
    .next_rd_o(next_rd), .ctx_rd_o(ctx_rd), .eirq_req_o(eirq),
    .tmr_en_clr_o(tclr), .sw_en_clr_o(sclr), .tmr_en_set_o(tset), .sw_en_set_o(sset)
  );

  // Bench model of the context, built from the requirements
  logic [3:0] m_ppp = 0, m_pp = 0;
  logic [4:0] m_pre = 0;
  logic m_noirq = 1, m_arm = 0;
  logic [8:0] m_irq = 0;

  typedef struct {
    bit          is_ctx;
    logic [31:0] val;
    string       tag;
  } item_t;
  item_t exp_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_sel(output logic v, output logic [8:0] idx, output logic [3:0] p);
    v = 0; idx = 0; p = 0;
    for (int i = 0; i < N; i++) begin
      logic [3:0] pi;
      pi = prio[i*4 +: 4];
      if (pend[i] && en[i] && pi >= m_pp && (!v || pi > p)) begin
        v = 1; idx = 9'(i); p = pi;
      end
    end
  endtask

  function automatic logic [31:0] ctx_word(logic ts, logic ss);
    return {m_ppp, m_pp, 3'b0, m_pre, m_noirq, 2'b0, m_irq, ts, ss, 1'b0, m_arm};
  endfunction

  // Driver: called after inputs were set at a negedge; predicts both outputs
  task automatic cycle(string tag);
    logic v; logic [8:0] idx; logic [3:0] p;
    logic ts, ss;
    item_t it;
    model_sel(v, idx, p);
    it.is_ctx = 0; it.val = {~v, 20'd0, idx, 2'b00}; it.tag = {tag, " next"};
    exp_q.push_back(it);
    ts = wen && wdata[1] && tmr_en;
    ss = wen && wdata[1] && sw_en;
    if (vent) begin
      m_ppp = m_pp; m_pp = m_pre[3:0]; m_arm = 1;
    end else if (otrap) begin
      m_arm = 0;
    end else if (mret) begin
      if (m_arm) begin m_pre = {1'b0, m_pp}; m_pp = m_ppp; m_ppp = 0; end
      m_arm = 0;
    end else if (upd) begin
      m_irq = idx; m_noirq = ~v; m_pre = v ? 5'({1'b0, p} + 5'd1) : 5'd16;
    end else if (wen) begin
      m_ppp = wdata[31:28]; m_pp = wdata[27:24]; m_pre = wdata[20:16];
      m_noirq = wdata[15]; m_irq = wdata[12:4]; m_arm = wdata[0];
    end
    it.is_ctx = 1; it.val = ctx_word(ts, ss); it.tag = {tag, " ctx"};
    exp_q.push_back(it);
    @(negedge clk);
    upd = 0; wen = 0; vent = 0; otrap = 0; mret = 0; wdata = '0;
  endtask

  // Monitor: compares registered outputs shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        chk(it.tag, it.is_ctx ? ctx_rd : next_rd, it.val);
      end
    end
  end

  function automatic logic [N*4-1:0] set_prio(logic [N*4-1:0] base, int line, logic [3:0] val);
    logic [N*4-1:0] r;
    r = base;
    r[line*4 +: 4] = val;
    return r;
  endfunction

  initial begin
    #(8 * 100000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #20;
    // R3 R5: reset values
    chk("R3 reset next", next_rd, 32'h8000_0000);
    chk("R5 reset ctx", ctx_rd, 32'h0000_8000);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R1: all priorities equal, lowest pending line wins
    pend = 8'b0000_0101; en = '1; prio = '0;
    cycle("R1 equal prio");
    // R1: higher priority beats lower number
    prio = set_prio(set_prio('0, 0, 4'd3), 2, 4'd5);
    cycle("R1 priority order");
    // R1: tie at the top resolves to the lowest number
    pend = 8'b0010_0010; prio = set_prio(set_prio('0, 1, 4'd7), 5, 4'd7);
    cycle("R1 tie lowest");
    // R1: disabled line ignored
    en = 8'b1111_1101;
    cycle("R1 enable mask");
    // R4: update loads line 5, preempt 8
    upd = 1;
    cycle("R4 update");
    // R10: preempt is now 8, a priority-7 line does not request
    #1; n_checks++; if (eirq !== 1'b0) begin n_errors++; $display("FAIL R10 actual=%b expected=0", eirq); end
    pend = 8'b0010_1000; prio = set_prio(prio, 3, 4'd8);
    #1; chk("R10 equal preempt requests", {31'd0, eirq}, 32'd1);
    // R6: vector entry pushes
    vent = 1;
    cycle("R6 push");
    // R2: floor is 8, line 3 at 8 eligible, line 5 at 7 not
    cycle("R2 floor equal");
    pend = 8'b0010_0000;
    cycle("R2 below floor");
    #1; chk("R10 below preempt", {31'd0, eirq}, 32'd0);
    // R4: update with nothing selected
    upd = 1;
    cycle("R4 empty update");
    // R7: armed return pops
    mret = 1;
    cycle("R7 pop");
    // R7: unarmed return leaves stack
    mret = 1;
    cycle("R7 no pop");
    // R8: entry then other trap
    vent = 1;
    cycle("R8 entry");
    otrap = 1;
    cycle("R8 other trap");
    mret = 1;
    cycle("R8 return after trap");
    // R11: software write of all fields
    wen = 1; wdata = {4'h3, 4'h2, 3'b0, 5'h01, 1'b0, 2'b0, 9'h0AB, 1'b0, 1'b0, 1'b0, 1'b1};
    cycle("R11 write");
    // R9: clear wins over set, prior enables shown
    tmr_en = 1; sw_en = 0;
    wen = 1; wdata = 32'h0000_800E;
    #1;
    chk("R9 clear strobes", {30'd0, tclr, sclr}, 32'd3);
    chk("R9 clear beats set", {30'd0, tset, sset}, 32'd0);
    cycle("R9 clear save");
    // R9: set strobes without clear
    tmr_en = 0; sw_en = 1;
    wen = 1; wdata = 32'h0000_800C;
    #1;
    chk("R9 set strobes", {28'd0, tset, sset, tclr, sclr}, 32'hC);
    cycle("R9 set no save");

    @(negedge clk); @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule